// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is a per-processor countdown timer that raises a fixed, edge-style interrupt request when its count runs out. Software programs it through a small register port. It can set a global enable, a 32-bit start value, a three-bit prescaler code and a group of local interrupt entries. Entry 0 belongs to the timer and carries its vector, its mask and its repeat mode. The other entries hold the configuration of other local interrupt sources. This block stores them but does not deliver them.

Writing the start value arms the timer. The count then drops by one every divisor cycles of the bus clock. When it reaches zero it either stops there or reloads and starts again. At each expiry the block emits a one-cycle request pulse, provided the block is enabled and the timer entry is unmasked. The pulse carries the entry's vector.

The countdown is a state machine with three states:
- `TS_IDLE`: never armed, or armed with zero.
- `TS_RUN`: counting.
- `TS_DONE`: a one-shot count has reached zero.

The transitions are:
- *arm*: any state moves to `TS_RUN` on a non-zero start value.
- *disarm*: any state moves to `TS_IDLE` on a zero start value.
- *expire-once*: `TS_RUN` moves to `TS_DONE`.
- *expire-repeat*: `TS_RUN` stays in `TS_RUN` with a reload.
- *hold*: `TS_IDLE` and `TS_DONE` stay where they are.

Top module: `lct_timer`

## Requirements
- R1: The prescaler code is taken from divide-register (address 3) bits 3, 1 and 0 as the value {b3,b1,b0}. The shift is that value plus 1, modulo 8, and the divisor d is 2 to the power of the shift. So code 111 divides by 1 and code 000 divides by 2. Bit 2 and all higher bits are dropped, and a read returns only bits 3, 1 and 0.
- R2: A write to the start-value register (address 1) stores the value and cancels any count in progress. On that same clock edge it loads the current count with the new value and restarts the prescaler.
- R3: The current count (address 2, read-only, writes ignored) reads its live value. k cycles after the loading edge it reads N - floor(k/d), where N is the start value.
- R4: In one-shot mode (timer entry bit 17 clear), the count reaches zero after N*d cycles and stays at zero until the next start-value write.
- R5: In repeat mode (timer entry bit 17 set), the count reloads the start value on the expiry edge, so expiries occur every N*d cycles.
- R6: An expiry produces a request only when control bit 0 (address 0) is set and timer entry bit 16 (mask) is clear at the expiry edge. Otherwise the count behaves the same and no pulse appears.
- R7: The writable bits are as follows. Timer entry (address 4): bits 17, 16, 12 and 7:0. Other entries (addresses 5 to 9): bits 16, 12 and 7:0. Control register: bit 0. All other bits read as zero.
- R8: Writing control bit 0 as zero sets bit 16 in every entry and keeps the other bits. Entry writes made while control bit 0 is clear are stored with bit 16 set. Setting the enable again does not clear any mask.
- R9: After reset the control, start-value, count and divide registers read zero, every entry reads 0x0001_0000, and `irq_o` is low.
- R10: A start value of zero leaves the timer idle, with the count at zero and no request.
- R11: `irq_o` is high for exactly the one cycle after each expiry edge. `irq_vec_o` then shows timer entry bits 7:0 as they were at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write index |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | ADDR_W | Register read index |
| rd_data_o | output | 32 | Read data, combinational from `rd_addr_i` |
| irq_o | output | 1 | One-cycle interrupt request pulse |
| irq_vec_o | output | 8 | Vector of the latest request |

## Verification
A register write takes effect on the clock edge that samples it, and reads are combinational, so a readback is valid in the same low phase as the write completes.

Let k count the edges after the loading edge. The count then equals N - floor(k/d). The request pulse is visible in the cycle that follows edge N*d, or multiples of it in repeat mode.

The bench drives and samples only at falling edges and counts k from the loading edge. It compares the count and the request every single cycle against these formulas, computed from the prescaler code. It sweeps all sixteen divide-register values, so every divisor is covered and bit 2 is shown to be ignored.

// File: rtl/lct_pkg.sv
package lct_pkg;

    localparam int DATA_W  = 32;
    localparam int VEC_W   = 8;
    localparam int SEL_W   = 3;
    // largest divisor is 2**(2**SEL_W - 1); prescaler counts up to divisor-1
    localparam int PRE_W   = (1 << SEL_W) - 1;

    localparam int BIT_MASK     = 16;
    localparam int BIT_PERIODIC = 17;

    localparam logic [DATA_W-1:0] TMR_WMASK = 32'h0003_10FF;
    localparam logic [DATA_W-1:0] AUX_WMASK = 32'h0001_10FF;
    localparam logic [DATA_W-1:0] ENT_RESET = 32'h0001_0000;

    localparam int A_CTRL = 0;
    localparam int A_INIT = 1;
    localparam int A_CUR  = 2;
    localparam int A_DIV  = 3;
    localparam int A_ENT0 = 4;

    typedef enum logic [1:0] {
        TS_IDLE = 2'd0,
        TS_RUN  = 2'd1,
        TS_DONE = 2'd2
    } tmr_state_e;

    // code is {b3,b1,b0}; shift wraps modulo 2**SEL_W
    function automatic logic [SEL_W-1:0] div_shift(input logic [SEL_W-1:0] code);
        return code + SEL_W'(1);
    endfunction

endpackage

// File: rtl/lct_prescaler.sv
module lct_prescaler
    import lct_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    input  logic             run_i,
    input  logic [SEL_W-1:0] code_i,
    output logic             tick_o
);

    logic [SEL_W-1:0] shift;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] limit;
    logic [PRE_W-1:0] cnt_q;

    assign shift  = div_shift(code_i);
    assign span   = (PRE_W+1)'(1) << shift;
    assign limit  = PRE_W'(span - (PRE_W+1)'(1));
    // >= keeps the prescaler safe when the divisor shrinks mid-count
    assign tick_o = run_i && !restart_i && (cnt_q >= limit);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (restart_i || !run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/lct_countdown.sv
module lct_countdown
    import lct_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [CNT_W-1:0] reload_val_i,
    input  logic             tick_i,
    input  logic             periodic_i,
    input  logic             fire_ok_i,
    output logic [CNT_W-1:0] count_o,
    output logic             run_o,
    output logic             expire_o,
    output logic             fire_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic             fire_q;
    logic             expire_c;

    // next-state logic
    always_comb begin
        state_d  = state_q;
        expire_c = 1'b0;
        if (load_i) begin
            state_d = (load_val_i == '0) ? TS_IDLE : TS_RUN;   // disarm / arm
        end else begin
            unique case (state_q)
                TS_IDLE, TS_DONE: state_d = state_q;           // hold
                TS_RUN: begin
                    if (tick_i && (count_q == ONE)) begin
                        expire_c = 1'b1;
                        state_d  = periodic_i ? TS_RUN : TS_DONE; // expire-repeat / expire-once
                    end
                end
                default: state_d = TS_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= TS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            count_q <= '0;
            fire_q  <= 1'b0;
        end else begin
            fire_q <= expire_c && fire_ok_i;
            if (load_i) begin
                count_q <= load_val_i;
            end else if (expire_c) begin
                count_q <= periodic_i ? reload_val_i : '0;
            end else if ((state_q == TS_RUN) && tick_i) begin
                count_q <= count_q - ONE;
            end
        end
    end

    assign count_o  = count_q;
    assign run_o    = (state_q == TS_RUN);
    assign expire_o = expire_c;
    assign fire_o   = fire_q;

endmodule

// File: rtl/lct_regs.sv
module lct_regs
    import lct_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int NUM_ENT = 6,
    parameter int CNT_W   = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic [CNT_W-1:0]  cur_count_i,
    output logic              sw_en_o,
    output logic [CNT_W-1:0]  init_o,
    output logic [SEL_W-1:0]  div_code_o,
    output logic [VEC_W-1:0]  tmr_vec_o,
    output logic              tmr_mask_o,
    output logic              tmr_periodic_o,
    output logic              load_o
);

    logic                          sw_en_q;
    logic [CNT_W-1:0]              init_q;
    logic [SEL_W-1:0]              div_q;
    logic [NUM_ENT-1:0][DATA_W-1:0] ent_w;
    logic                          hit_ctrl, hit_init, hit_div, mask_all;

    assign hit_ctrl = wr_en_i && (wr_addr_i == ADDR_W'(A_CTRL));
    assign hit_init = wr_en_i && (wr_addr_i == ADDR_W'(A_INIT));
    assign hit_div  = wr_en_i && (wr_addr_i == ADDR_W'(A_DIV));
    assign mask_all = hit_ctrl && !wr_data_i[0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sw_en_q <= 1'b0;
            init_q  <= '0;
            div_q   <= '0;
        end else begin
            if (hit_ctrl) sw_en_q <= wr_data_i[0];
            if (hit_init) init_q  <= wr_data_i[CNT_W-1:0];
            if (hit_div)  div_q   <= {wr_data_i[3], wr_data_i[1:0]};
        end
    end

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        localparam logic [DATA_W-1:0] WMASK = (g == 0) ? TMR_WMASK : AUX_WMASK;
        logic              hit;
        logic [DATA_W-1:0] q;
        assign hit = wr_en_i && (wr_addr_i == ADDR_W'(A_ENT0 + g));
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                q <= ENT_RESET;
            end else if (mask_all) begin
                q <= q | ENT_RESET;
            end else if (hit) begin
                q <= (wr_data_i & WMASK) | (sw_en_q ? '0 : ENT_RESET);
            end
        end
        assign ent_w[g] = q;
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == ADDR_W'(A_CTRL)) rd_data_o = DATA_W'(sw_en_q);
        if (rd_addr_i == ADDR_W'(A_INIT)) rd_data_o = DATA_W'(init_q);
        if (rd_addr_i == ADDR_W'(A_CUR))  rd_data_o = DATA_W'(cur_count_i);
        if (rd_addr_i == ADDR_W'(A_DIV))  rd_data_o = DATA_W'({div_q[2], 1'b0, div_q[1:0]});
        for (int i = 0; i < NUM_ENT; i++) begin
            if (rd_addr_i == ADDR_W'(A_ENT0 + i)) rd_data_o = ent_w[i];
        end
    end

    assign sw_en_o        = sw_en_q;
    assign init_o         = init_q;
    assign div_code_o     = div_q;
    assign tmr_vec_o      = ent_w[0][VEC_W-1:0];
    assign tmr_mask_o     = ent_w[0][BIT_MASK];
    assign tmr_periodic_o = ent_w[0][BIT_PERIODIC];
    assign load_o         = hit_init;

endmodule

// File: rtl/lct_timer.sv
module lct_timer
    import lct_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int NUM_ENT = 6,
    parameter int CNT_W   = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o,
    output logic [VEC_W-1:0]  irq_vec_o
);

    logic              sw_en, tmr_mask, tmr_periodic, load_init;
    logic              tick, running, expire, fire;
    logic [CNT_W-1:0]  init_q, cur_count, load_val;
    logic [SEL_W-1:0]  div_code;
    logic [VEC_W-1:0]  tmr_vec, vec_q;

    assign load_val = wr_data_i[CNT_W-1:0];

    lct_regs #(
        .ADDR_W (ADDR_W),
        .NUM_ENT(NUM_ENT),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .wr_en_i       (wr_en_i),
        .wr_addr_i     (wr_addr_i),
        .wr_data_i     (wr_data_i),
        .rd_addr_i     (rd_addr_i),
        .rd_data_o     (rd_data_o),
        .cur_count_i   (cur_count),
        .sw_en_o       (sw_en),
        .init_o        (init_q),
        .div_code_o    (div_code),
        .tmr_vec_o     (tmr_vec),
        .tmr_mask_o    (tmr_mask),
        .tmr_periodic_o(tmr_periodic),
        .load_o        (load_init)
    );

    lct_prescaler u_pre (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .restart_i(load_init),
        .run_i    (running),
        .code_i   (div_code),
        .tick_o   (tick)
    );

    lct_countdown #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (load_init),
        .load_val_i  (load_val),
        .reload_val_i(init_q),
        .tick_i      (tick),
        .periodic_i  (tmr_periodic),
        .fire_ok_i   (sw_en && !tmr_mask),
        .count_o     (cur_count),
        .run_o       (running),
        .expire_o    (expire),
        .fire_o      (fire)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            vec_q <= '0;
        end else if (expire) begin
            vec_q <= tmr_vec;
        end
    end

    assign irq_o     = fire;
    assign irq_vec_o = vec_q;

endmodule

// File: rtl/lct_timer_chk.sv
module lct_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             load_i,
    input logic [CNT_W-1:0] load_val_i,
    input logic [CNT_W-1:0] count_i,
    input logic [CNT_W-1:0] reload_i,
    input logic             sw_en_i,
    input logic             mask_i,
    input logic             irq_i
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R2
    load_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (count_i == $past(load_val_i)));

    // R3
    count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && count_i != '0) |=>
            ((count_i == $past(count_i)) || (count_i == $past(count_i) - ONE) ||
             (($past(count_i) == ONE) && (count_i == $past(reload_i)))));

    // R4
    zero_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && count_i == '0) |=> (count_i == '0));

    // R6
    irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_i |-> $past(sw_en_i && !mask_i));

    // R8
    disable_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sw_en_i |-> mask_i);

endmodule

bind lct_timer lct_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_init),
    .load_val_i(load_val),
    .count_i   (cur_count),
    .reload_i  (init_q),
    .sw_en_i   (sw_en),
    .mask_i    (tmr_mask),
    .irq_i     (irq_o)
);

// File: tb/lct_timer_bench.sv
module lct_timer_bench;

    localparam int AW     = 4;
    localparam int A_CTRL = 0;
    localparam int A_INIT = 1;
    localparam int A_CUR  = 2;
    localparam int A_DIV  = 3;
    localparam int A_ENT0 = 4;
    localparam int NENT   = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [31:0]   wr_data;
    logic [AW-1:0] rd_addr;
    logic [31:0]   rd_data;
    logic          irq;
    logic [7:0]    irq_vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    lct_timer u_lct_timer (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .wr_en_i  (wr_en),
        .wr_addr_i(wr_addr),
        .wr_data_i(wr_data),
        .rd_addr_i(rd_addr),
        .rd_data_o(rd_data),
        .irq_o    (irq),
        .irq_vec_o(irq_vec)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input int a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        rd_addr = AW'(a);
        #1;
        v = rd_data;
    endtask

    // count and request every cycle against N - floor(k/d)
    task automatic sweep(input int c, input int n, input bit per);
        int d, nd, expc, last;
        bit expi;
        d  = 1 << ((((c >> 3) & 1) * 4 + (c & 3) + 1) % 8);
        nd = n * d;
        wr(A_CTRL, 1);
        wr(A_ENT0, 32'h40 + c + (per ? 32'h2_0000 : 0));
        wr(A_DIV, c);
        rd_addr = AW'(A_CUR);
        wr(A_INIT, n);
        last = per ? 2 * nd + 2 : nd + 3;
        for (int k = 0; k <= last; k++) begin
            if (per) begin
                expc = n - ((k % nd) / d);
                expi = (k > 0) && (k % nd == 0);
            end else begin
                expc = (k >= nd) ? 0 : n - k / d;
                expi = (k == nd);
            end
            #1;
            chk($sformatf("R1/R3 %s cfg=%0h k=%0d count", per ? "R5" : "R4", c, k), rd_data, expc);
            chk($sformatf("R11 cfg=%0h k=%0d irq", c, k), {31'b0, irq}, {31'b0, expi});
            if (expi) chk($sformatf("R11 cfg=%0h vector", c), {24'b0, irq_vec}, 32'h40 + c);
            @(negedge clk);
        end
        if (per) wr(A_INIT, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        rd(A_CTRL, v); chk("R9 ctrl", v, 0);
        rd(A_INIT, v); chk("R9 init", v, 0);
        rd(A_CUR, v);  chk("R9 count", v, 0);
        rd(A_DIV, v);  chk("R9 div", v, 0);
        for (int i = 0; i < NENT; i++) begin
            rd(A_ENT0 + i, v); chk($sformatf("R9 entry%0d", i), v, 32'h0001_0000);
        end
        chk("R9 irq", {31'b0, irq}, 0);
        @(negedge clk);

        // R10 zero start value stays idle
        wr(A_CTRL, 1); wr(A_ENT0, 32'h33); wr(A_DIV, 32'hB);
        rd_addr = AW'(A_CUR);
        wr(A_INIT, 0);
        for (int k = 0; k < 8; k++) begin
            #1;
            chk("R10 count", rd_data, 0);
            chk("R10 irq", {31'b0, irq}, 0);
            @(negedge clk);
        end

        // R7 writable bits
        wr(A_ENT0, 32'hFFFF_FFFF);     rd(A_ENT0, v);     chk("R7 timer entry", v, 32'h0003_10FF);
        @(negedge clk);
        wr(A_ENT0 + 1, 32'hFFFF_FFFF); rd(A_ENT0 + 1, v); chk("R7 other entry", v, 32'h0001_10FF);
        @(negedge clk);
        wr(A_CTRL, 32'hFFFF_FFFF);     rd(A_CTRL, v);     chk("R7 ctrl", v, 1);
        @(negedge clk);
        wr(A_DIV, 32'hFFFF_FFFF);      rd(A_DIV, v);      chk("R1 div readback", v, 32'hB);
        @(negedge clk);
        wr(A_CUR, 32'h55);             rd(A_CUR, v);      chk("R3 count read-only", v, 0);
        @(negedge clk);
        wr(A_INIT, 32'hFFFF_FFFF);     rd(A_INIT, v);     chk("R2 init readback", v, 32'hFFFF_FFFF);
        @(negedge clk);
        wr(A_INIT, 0);                 rd(A_CUR, v);      chk("R10 stop", v, 0);
        @(negedge clk);

        // R1 R3 R4 R11 one-shot over every divide value
        for (int c = 0; c < 16; c++) sweep(c, 3, 1'b0);
        // R5 repeat mode
        sweep(4'b0011, 3, 1'b1);
        sweep(4'b1011, 3, 1'b1);
        sweep(4'b0000, 2, 1'b1);
        for (int k = 0; k < 6; k++) begin
            #1;
            chk("R10 after repeat count", rd_data, 0);
            chk("R10 after repeat irq", {31'b0, irq}, 0);
            @(negedge clk);
        end

        // R2 restart mid-count, divisor 2
        wr(A_ENT0, 32'h5A); wr(A_DIV, 0);
        rd_addr = AW'(A_CUR);
        wr(A_INIT, 10);
        repeat (5) @(negedge clk);
        #1; chk("R2 before restart", rd_data, 8);
        @(negedge clk);
        wr(A_INIT, 4);
        for (int k = 0; k <= 9; k++) begin
            #1;
            chk($sformatf("R2 k=%0d count", k), rd_data, (k >= 8) ? 0 : 4 - k / 2);
            chk($sformatf("R2 k=%0d irq", k), {31'b0, irq}, {31'b0, (k == 8)});
            @(negedge clk);
        end

        // R6 masked entry: count runs, no request
        wr(A_ENT0, 32'h1_0077); wr(A_DIV, 32'hB);
        rd_addr = AW'(A_CUR);
        wr(A_INIT, 2);
        for (int k = 0; k <= 5; k++) begin
            #1;
            chk($sformatf("R6 k=%0d count", k), rd_data, (k >= 2) ? 0 : 2 - k);
            chk($sformatf("R6 k=%0d irq", k), {31'b0, irq}, 0);
            @(negedge clk);
        end

        // R8 software disable masks every entry
        for (int i = 0; i < NENT; i++) wr(A_ENT0 + i, 32'h20 + i);
        wr(A_CTRL, 0);
        for (int i = 0; i < NENT; i++) begin
            rd(A_ENT0 + i, v); chk($sformatf("R8 entry%0d masked", i), v, 32'h1_0020 + i);
        end
        @(negedge clk);
        wr(A_ENT0, 32'h25); rd(A_ENT0, v); chk("R8 write while disabled", v, 32'h1_0025);
        @(negedge clk);
        rd_addr = AW'(A_CUR);
        wr(A_INIT, 2);
        for (int k = 0; k <= 4; k++) begin
            #1; chk($sformatf("R6 disabled k=%0d irq", k), {31'b0, irq}, 0);
            @(negedge clk);
        end
        wr(A_CTRL, 1); rd(A_ENT0, v); chk("R8 stays masked", v, 32'h1_0025);
        @(negedge clk);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule